// File: doc/BRIEF.md
# Depth-Cascade Token Controller for Chained FIFO Banks

This block joins several identical FIFO banks into one deeper FIFO. It does not decode addresses. A write token and a read token each travel around a ring of bank stages. The stage that holds the write token is the only one whose bank is allowed to store incoming words. The stage that holds the read token is the only one whose bank is allowed to give up words and drive the shared output.

Each stage tracks which physical location of its bank comes next. When a stage writes or reads its bank's last location, it raises a one-clock expansion pulse toward the next stage in the ring. The next stage takes the token on the following rising edge. A per-stage first-load strap picks the stage that owns both tokens after reset. The block also merges the per-bank status flags into composite empty, full, almost-empty and almost-full outputs. No half-full output exists in this configuration.

The storage arrays and the offset programming sit outside this block. The read and write sides share one clock, as in single-clock operation.

Top module: `fifo_cascade_ctrl`

## Requirements
- R1: After reset, the stage whose `first_load_n` bit is 0 holds both the write token and the read token, and no other stage holds a token. Exactly one strap bit is expected to be 0.
- R2: `bank_wen[k]` is 1 only when `wr_en` is 1, stage k holds the write token and `bank_full[k]` is 0. A stage without the token, or with a full bank, ignores `wr_en` and does not advance its write location.
- R3: `bank_ren[k]` is 1 only when `rd_en` is 1, stage k holds the read token and `bank_empty[k]` is 0. A stage without the token, or with an empty bank, ignores `rd_en` and does not advance its read location.
- R4: In the cycle a stage writes location DEPTH-1 of its bank, its `wr_xo` bit is 1 for exactly that one clock. On the next rising edge the write token moves to stage k+1, and the last stage passes it back to stage 0.
- R5: In the cycle a stage reads location DEPTH-1 of its bank, its `rd_xo` bit is 1 for exactly that one clock. On the next rising edge the read token moves to the next stage in the same ring order.
- R6: `bank_oe[k]` is 1 only when `out_en` is 1 and stage k holds the read token. `rd_data` is that stage's slice of `bank_rdata` (bits k*DATA_W and up) when `out_en` is 1, and all zeros when `out_en` is 0.
- R7: Each composite flag (`cas_empty`, `cas_full`, `cas_aempty`, `cas_afull`) is 1 exactly when the matching per-bank flag is 1 on every stage. This makes the almost flags approximate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared read/write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_load_n | input | N | Per-stage strap; 0 marks the stage that starts with the tokens |
| wr_en | input | 1 | Cascade write request |
| rd_en | input | 1 | Cascade read request |
| out_en | input | 1 | Output enable for the shared read data |
| bank_full | input | N | Per-bank full flag |
| bank_empty | input | N | Per-bank empty flag |
| bank_aempty | input | N | Per-bank almost-empty flag |
| bank_afull | input | N | Per-bank almost-full flag |
| bank_rdata | input | N*DATA_W | Per-bank read data, stage k at bits k*DATA_W and up |
| bank_wen | output | N | Gated write enable to each bank |
| bank_ren | output | N | Gated read enable to each bank |
| bank_oe | output | N | Output drive enable to each bank |
| wr_xo | output | N | Write expansion pulse of each stage |
| rd_xo | output | N | Read expansion pulse of each stage |
| rd_data | output | DATA_W | Selected read data |
| cas_empty | output | 1 | Composite empty |
| cas_full | output | 1 | Composite full |
| cas_aempty | output | 1 | Composite almost-empty |
| cas_afull | output | 1 | Composite almost-full |

## Verification
The bench runs the write token all the way around the ring and back to stage 0. A design that forgot the wrap would leave every bank write-disabled after the last stage. It also stalls a token holder with a full or empty bank for a cycle and then checks where the hand-off lands. A controller that advanced its location counter while blocked would hand the token on one word early. Separately, it moves the reset strap to a stage other than stage 0, and it switches the output enable off, which must silence both the drive enables and the data.

// File: rtl/fifo_cascade_pkg.sv
package fifo_cascade_pkg;
  function automatic int loc_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/cascade_rst_sync.sv
module cascade_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cascade_token_stage.sv
module cascade_token_stage
  import fifo_cascade_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_n,
  input  logic xi,
  input  logic req,
  input  logic blocked,
  output logic tok,
  output logic grant,
  output logic xo
);
  localparam int LOC_W = loc_bits(DEPTH);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(DEPTH - 1);

  logic [LOC_W-1:0] loc_q, loc_d;
  logic             tok_q, tok_d;
  logic             at_last;

  assign at_last = (loc_q == LAST_LOC);
  assign grant   = tok_q & req & ~blocked;
  assign xo      = grant & at_last;
  assign tok     = tok_q;

  always_comb begin
    loc_d = loc_q;
    if (grant) loc_d = at_last ? '0 : loc_q + 1'b1;
    tok_d = tok_q;
    if (xo) tok_d = 1'b0;
    if (xi) tok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      tok_q <= ~strap_n;
    end else begin
      loc_q <= loc_d;
      tok_q <= tok_d;
    end
  end

  // R2 / R3: a stalled or token-less stage keeps its location
  a_r2_idle_holds_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_q || !req || blocked) |=> $stable(loc_q));
endmodule

// File: rtl/cascade_flag_merge.sv
module cascade_flag_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] empty_v,
  input  logic [N-1:0] full_v,
  input  logic [N-1:0] aempty_v,
  input  logic [N-1:0] afull_v,
  output logic         empty_o,
  output logic         full_o,
  output logic         aempty_o,
  output logic         afull_o
);
  assign empty_o  = &empty_v;
  assign full_o   = &full_v;
  assign aempty_o = &aempty_v;
  assign afull_o  = &afull_v;
endmodule

// File: rtl/fifo_cascade_ctrl.sv
module fifo_cascade_ctrl #(
  parameter int N      = 3,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      first_load_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              out_en,
  input  logic [N-1:0]      bank_full,
  input  logic [N-1:0]      bank_empty,
  input  logic [N-1:0]      bank_aempty,
  input  logic [N-1:0]      bank_afull,
  input  logic [N*DATA_W-1:0] bank_rdata,
  output logic [N-1:0]      bank_wen,
  output logic [N-1:0]      bank_ren,
  output logic [N-1:0]      bank_oe,
  output logic [N-1:0]      wr_xo,
  output logic [N-1:0]      rd_xo,
  output logic [DATA_W-1:0] rd_data,
  output logic              cas_empty,
  output logic              cas_full,
  output logic              cas_aempty,
  output logic              cas_afull
);
  logic          rst_q_n;
  logic [N-1:0]  wr_tok, rd_tok;
  logic [N-1:0]  wr_xi, rd_xi;
  logic [DATA_W-1:0] sel_data;

  cascade_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  for (genvar k = 0; k < N; k++) begin : g_stage
    localparam int PREV = (k == 0) ? N - 1 : k - 1;
    localparam int NEXT = (k == N - 1) ? 0 : k + 1;

    assign wr_xi[k] = wr_xo[PREV];
    assign rd_xi[k] = rd_xo[PREV];

    cascade_token_stage #(.DEPTH(DEPTH)) u_wr (
      .clk(clk), .rst_n(rst_q_n), .strap_n(first_load_n[k]),
      .xi(wr_xi[k]), .req(wr_en), .blocked(bank_full[k]),
      .tok(wr_tok[k]), .grant(bank_wen[k]), .xo(wr_xo[k]));

    cascade_token_stage #(.DEPTH(DEPTH)) u_rd (
      .clk(clk), .rst_n(rst_q_n), .strap_n(first_load_n[k]),
      .xi(rd_xi[k]), .req(rd_en), .blocked(bank_empty[k]),
      .tok(rd_tok[k]), .grant(bank_ren[k]), .xo(rd_xo[k]));

    assign bank_oe[k] = out_en & rd_tok[k];

    // R4 / R5: hand-off lands on the next stage one edge later
    a_r4_wpass: assert property (@(posedge clk) disable iff (!rst_q_n)
      wr_xo[k] |=> wr_tok[NEXT]);
    a_r5_rpass: assert property (@(posedge clk) disable iff (!rst_q_n)
      rd_xo[k] |=> rd_tok[NEXT]);
  end

  always_comb begin
    sel_data = '0;
    for (int k = 0; k < N; k++)
      if (rd_tok[k]) sel_data = sel_data | bank_rdata[k*DATA_W +: DATA_W];
  end

  assign rd_data = out_en ? sel_data : '0;

  cascade_flag_merge #(.N(N)) u_flags (
    .empty_v(bank_empty), .full_v(bank_full),
    .aempty_v(bank_aempty), .afull_v(bank_afull),
    .empty_o(cas_empty), .full_o(cas_full),
    .aempty_o(cas_aempty), .afull_o(cas_afull));

  // R1: exactly one holder of each token
  a_r1_one_wtoken: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(wr_tok) == 1);
  a_r1_one_rtoken: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(rd_tok) == 1);
  // R3 / R7: composite empty forbids any bank read
  a_r3_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_q_n)
    cas_empty |-> (bank_ren == '0));
  // R6: at most one bank drives the output
  a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(bank_oe));
endmodule

// File: tb/fifo_cascade_ctrl_tb_top.sv
module fifo_cascade_ctrl_tb_top;
  localparam int N = 3, DEPTH = 4, DW = 8;
  localparam int NV = 23;
  // {wr,rd,full[3],empty[3],exp_wen[3],exp_ren[3],exp_wxo[3],exp_rxo[3]}
  localparam logic [19:0] VEC [NV] = '{
    {2'b10,3'b000,3'b000,3'b001,3'b000,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b001,3'b000,3'b000,3'b000},
    {2'b11,3'b000,3'b000,3'b001,3'b001,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b001,3'b000,3'b001,3'b000},
    {2'b10,3'b010,3'b000,3'b000,3'b000,3'b000,3'b000},
    {2'b01,3'b000,3'b001,3'b000,3'b000,3'b000,3'b000},
    {2'b11,3'b000,3'b000,3'b010,3'b001,3'b000,3'b000},
    {2'b01,3'b000,3'b000,3'b000,3'b001,3'b000,3'b000},
    {2'b01,3'b000,3'b000,3'b000,3'b001,3'b000,3'b001},
    {2'b01,3'b000,3'b000,3'b000,3'b010,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b010,3'b000,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b010,3'b000,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b010,3'b000,3'b010,3'b000},
    {2'b10,3'b000,3'b000,3'b100,3'b000,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b100,3'b000,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b100,3'b000,3'b000,3'b000},
    {2'b10,3'b000,3'b000,3'b100,3'b000,3'b100,3'b000},
    {2'b10,3'b000,3'b000,3'b001,3'b000,3'b000,3'b000},
    {2'b01,3'b000,3'b000,3'b000,3'b010,3'b000,3'b000},
    {2'b01,3'b000,3'b000,3'b000,3'b010,3'b000,3'b000},
    {2'b01,3'b000,3'b000,3'b000,3'b010,3'b000,3'b010},
    {2'b01,3'b000,3'b000,3'b000,3'b100,3'b000,3'b000},
    {2'b11,3'b001,3'b100,3'b000,3'b000,3'b000,3'b000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] first_load_n;
  logic wr_en, rd_en, out_en;
  logic [N-1:0] bank_full, bank_empty, bank_aempty, bank_afull;
  logic [N*DW-1:0] bank_rdata;
  logic [N-1:0] bank_wen, bank_ren, bank_oe, wr_xo, rd_xo;
  logic [DW-1:0] rd_data;
  logic cas_empty, cas_full, cas_aempty, cas_afull;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fifo_cascade_ctrl #(.N(N), .DEPTH(DEPTH), .DATA_W(DW)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [N-1:0] strap);
    rst_n = 1'b0; first_load_n = strap;
    wr_en = 0; rd_en = 0; out_en = 0;
    bank_full = '0; bank_empty = '0; bank_aempty = '0; bank_afull = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bank_rdata = {8'hC3, 8'hB2, 8'hA1};
    do_reset(3'b110);
    // R1 reset state: stage 0 holds both tokens
    wr_en = 1; rd_en = 1; #5;
    chk("R1 wen after reset", 32'(bank_wen), 32'b001);
    chk("R1 ren after reset", 32'(bank_ren), 32'b001);
    chk("R4 no pulse after reset", 32'(wr_xo), 32'b000);
    do_reset(3'b110);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en, rd_en, bank_full, bank_empty} = VEC[i][19:12];
      #5;
      chk($sformatf("R2 bank_wen vec%0d", i), 32'(bank_wen), 32'(VEC[i][11:9]));
      chk($sformatf("R3 bank_ren vec%0d", i), 32'(bank_ren), 32'(VEC[i][8:6]));
      chk($sformatf("R4 wr_xo vec%0d", i), 32'(wr_xo), 32'(VEC[i][5:3]));
      chk($sformatf("R5 rd_xo vec%0d", i), 32'(rd_xo), 32'(VEC[i][2:0]));
    end

    // R1 with strap on stage 2, R6 output selection
    do_reset(3'b011);
    wr_en = 1; rd_en = 1; out_en = 1; #5;
    chk("R1 strap2 wen", 32'(bank_wen), 32'b100);
    chk("R1 strap2 ren", 32'(bank_ren), 32'b100);
    chk("R6 bank_oe", 32'(bank_oe), 32'b100);
    chk("R6 rd_data", 32'(rd_data), 32'hC3);
    out_en = 0; #1;
    chk("R6 oe off bank_oe", 32'(bank_oe), 32'b000);
    chk("R6 oe off rd_data", 32'(rd_data), 32'h00);

    // R7 composite flags
    bank_empty = 3'b111; bank_full = 3'b110; bank_aempty = 3'b111; bank_afull = 3'b011; #1;
    chk("R7 empty all", 32'(cas_empty), 32'd1);
    chk("R7 full partial", 32'(cas_full), 32'd0);
    chk("R7 aempty all", 32'(cas_aempty), 32'd1);
    chk("R7 afull partial", 32'(cas_afull), 32'd0);
    bank_empty = 3'b101; bank_full = 3'b111; #1;
    chk("R7 empty partial", 32'(cas_empty), 32'd0);
    chk("R7 full all", 32'(cas_full), 32'd1);
    chk("R2 full blocks", 32'(bank_wen), 32'b000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule